// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block decides the answer an endpoint gives to each token from the host, and it keeps the endpoint's data toggle. Each token arrives as a one-cycle pulse with its type. The block weighs the following and returns one response code on the next clock edge:

- whether the transfer is in its status stage;
- whether the transmit buffer holds a valid packet;
- whether the receive buffer has room;
- whether the endpoint is isochronous;
- whether the endpoint is enabled;
- the two control bits held here, stall and status-acknowledge.

Packet transmission and CRC are handled elsewhere. For IN data, the packet engine reports the host's acknowledgement through a separate pulse. The block uses that pulse to advance the toggle, or to end the status stage after a zero-length packet.

Firmware sets the status-acknowledge bit once it is ready to finish a control transfer. The bit clears itself when the status stage completes, and also whenever a SETUP token is received. The stall bit makes a non-isochronous endpoint refuse IN and OUT traffic. Stalling the endpoint and releasing it leaves the data toggle where it was. The toggle goes back to DATA0 only when the endpoint is disabled and then enabled again.

Top module: `ctl_ep_responder`

## Requirements
- R1: A SETUP token (tok_type 2) on an enabled endpoint is always answered with ACK (resp_code 1), even when stalled. It sets the toggle to DATA1 and clears the status-acknowledge bit. The clear wins over a stsack_set pulse in the same cycle.
- R2: On a non-isochronous, non-stalled endpoint in the status stage, while status-acknowledge is 0, IN (tok_type 1) and OUT (tok_type 0) receive NAK (resp_code 2).
- R3: In the same conditions with status-acknowledge at 1, IN receives a zero-length packet (resp_code 5) tagged DATA1, and OUT receives ACK.
- R4: Status-acknowledge clears when the status stage completes. Completion is either an OUT answered with ACK in the status stage, or a host_ack pulse after a zero-length packet. At any other time, stsack_set sets the bit.
- R5: On a non-isochronous endpoint with the stall bit set, IN and OUT receive STALL (resp_code 3), ahead of every other response except R1.
- R6: On an isochronous endpoint, the stall bit is ignored. OUT gets no handshake (resp_valid high, resp_code 0). IN gets DATA (resp_code 4) tagged DATA0 if tx_valid is high, and a zero-length packet otherwise. The toggle is not changed.
- R7: Outside the status stage, IN receives DATA tagged with the current toggle if tx_valid is high, and NAK otherwise. OUT receives ACK if rx_free is high, and NAK otherwise.
- R8: The toggle flips on an OUT answered with ACK in the data stage. It also flips on a host_ack pulse that follows a non-isochronous DATA response with no token in between. NAK, STALL and host_ack without a pending DATA leave it unchanged.
- R9: Setting or clearing the stall bit never changes the toggle.
- R10: While ep_enable is 0, tokens get no response and the toggle is held at DATA0. After re-enabling, the first data packet is tagged DATA0.
- R11: resp_valid goes high exactly one cycle after an accepted token on an enabled endpoint. It stays low otherwise, including after tok_type 3, which is ignored.
- R12: stall_set sets the stall bit and stall_clr clears it. When both pulse in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_enable | input | 1 | Endpoint enable |
| ep_iso | input | 1 | Endpoint is isochronous |
| stall_set | input | 1 | Pulse: set stall bit |
| stall_clr | input | 1 | Pulse: clear stall bit |
| stsack_set | input | 1 | Pulse: set status-acknowledge bit |
| tok_valid | input | 1 | Token received this cycle |
| tok_type | input | 2 | 0 OUT, 1 IN, 2 SETUP, 3 ignored |
| status_stage | input | 1 | Transfer is in its status stage |
| tx_valid | input | 1 | Transmit buffer holds a validated packet |
| rx_free | input | 1 | Receive buffer can take a packet |
| host_ack | input | 1 | Host acknowledged the last packet sent |
| resp_valid | output | 1 | Response code valid |
| resp_code | output | 3 | 0 none, 1 ACK, 2 NAK, 3 STALL, 4 DATA, 5 zero-length |
| resp_data1 | output | 1 | Packet carries DATA1 (0 means DATA0) |
| stall_on | output | 1 | Stall bit |
| stsack_on | output | 1 | Status-acknowledge bit |
| toggle | output | 1 | Toggle for the next data packet |

## Verification
Two pairs of functions can land on the same cycle. The first pair is the automatic clear of status-acknowledge on a SETUP token and a firmware stsack_set pulse. The second pair is a host_ack pulse for a pending packet and a newly arriving token.

The bench drives each pair on the same edge. It then judges the outcome from the status-acknowledge and toggle ports: the SETUP clear must win, and the new token must cancel the pending acknowledgement.

A sweep covers every token type against every combination of stage, buffer flags, isochronous type, stall, status-acknowledge and starting toggle. After each token, the bench also follows it with a host_ack pulse.

// File: rtl/ctl_ep_responder.sv
module ctl_ep_responder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ep_enable,
  input  logic       ep_iso,
  input  logic       stall_set,
  input  logic       stall_clr,
  input  logic       stsack_set,
  input  logic       tok_valid,
  input  logic [1:0] tok_type,
  input  logic       status_stage,
  input  logic       tx_valid,
  input  logic       rx_free,
  input  logic       host_ack,
  output logic       resp_valid,
  output logic [2:0] resp_code,
  output logic       resp_data1,
  output logic       stall_on,
  output logic       stsack_on,
  output logic       toggle
);

  localparam logic [1:0] TK_OUT   = 2'd0;
  localparam logic [1:0] TK_IN    = 2'd1;
  localparam logic [1:0] TK_SETUP = 2'd2;

  localparam logic [2:0] RC_NONE  = 3'd0;
  localparam logic [2:0] RC_ACK   = 3'd1;
  localparam logic [2:0] RC_NAK   = 3'd2;
  localparam logic [2:0] RC_STALL = 3'd3;
  localparam logic [2:0] RC_DATA  = 3'd4;
  localparam logic [2:0] RC_ZLP   = 3'd5;

  logic       take, is_out, is_in, is_setup;
  logic [2:0] code_n;
  logic       tag_n;
  logic       pend_data, pend_zlp;
  logic       hack;
  logic       out_data_ack, status_done;

  assign is_out   = (tok_type == TK_OUT);
  assign is_in    = (tok_type == TK_IN);
  assign is_setup = (tok_type == TK_SETUP);
  assign take     = tok_valid && ep_enable && (tok_type != 2'd3);
  assign hack     = host_ack && !tok_valid;

  always_comb begin
    code_n = RC_NONE;
    tag_n  = 1'b0;
    if (is_setup) begin
      code_n = RC_ACK;
    end else if (ep_iso) begin
      if (is_in) code_n = tx_valid ? RC_DATA : RC_ZLP;
    end else if (stall_on) begin
      code_n = RC_STALL;
    end else if (status_stage) begin
      if (!stsack_on) begin
        code_n = RC_NAK;
      end else if (is_in) begin
        code_n = RC_ZLP;
        tag_n  = 1'b1;
      end else begin
        code_n = RC_ACK;
      end
    end else if (is_in) begin
      code_n = tx_valid ? RC_DATA : RC_NAK;
      tag_n  = tx_valid ? toggle : 1'b0;
    end else begin
      code_n = rx_free ? RC_ACK : RC_NAK;
    end
  end

  assign out_data_ack = take && is_out && !ep_iso && !status_stage && (code_n == RC_ACK);
  assign status_done  = (take && is_out && !ep_iso && status_stage && (code_n == RC_ACK))
                      || (hack && pend_zlp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_code  <= RC_NONE;
      resp_data1 <= 1'b0;
    end else begin
      resp_valid <= take;
      resp_code  <= take ? code_n : RC_NONE;
      resp_data1 <= take ? tag_n : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !ep_enable) begin
      pend_data <= 1'b0;
      pend_zlp  <= 1'b0;
    end else if (take) begin
      pend_data <= !ep_iso && (code_n == RC_DATA);
      pend_zlp  <= !ep_iso && (code_n == RC_ZLP);
    end else if (tok_valid || host_ack) begin
      pend_data <= 1'b0;
      pend_zlp  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !ep_enable)        toggle <= 1'b0;
    else if (take && is_setup)       toggle <= 1'b1;
    else if (out_data_ack)           toggle <= ~toggle;
    else if (hack && pend_data)      toggle <= ~toggle;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      stsack_on <= 1'b0;
    else if (take && is_setup)       stsack_on <= 1'b0;
    else if (status_done)            stsack_on <= 1'b0;
    else if (stsack_set)             stsack_on <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      stall_on <= 1'b0;
    else if (stall_set)              stall_on <= 1'b1;
    else if (stall_clr)              stall_on <= 1'b0;
  end

  // R1
  setup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && ep_enable && tok_type == TK_SETUP) |=> (resp_code == RC_ACK && !stsack_on && toggle));

  // R5
  stall_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && ep_enable && !ep_iso && stall_on && (tok_type == TK_IN || tok_type == TK_OUT))
      |=> (resp_code == RC_STALL));

  // R6
  iso_no_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && ep_enable && ep_iso && (tok_type == TK_IN || tok_type == TK_OUT))
      |=> (resp_code == RC_NONE || resp_code == RC_DATA || resp_code == RC_ZLP) && $stable(toggle));

  // R10
  disabled_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_enable |=> (!toggle && !resp_valid));

  // R11
  no_tok_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> !resp_valid);

  // R9
  idle_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_enable && !tok_valid && !host_ack) |=> $stable(toggle));

  // R12
  stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_set |=> stall_on);

endmodule

// File: tb/ctl_ep_responder_tb.sv
module ctl_ep_responder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ep_enable = 1'b0, ep_iso = 1'b0, stall_set = 1'b0, stall_clr = 1'b0, stsack_set = 1'b0;
  logic tok_valid = 1'b0, status_stage = 1'b0, tx_valid = 1'b0, rx_free = 1'b0, host_ack = 1'b0;
  logic [1:0] tok_type = 2'd0;
  logic resp_valid, resp_data1, stall_on, stsack_on, toggle;
  logic [2:0] resp_code;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctl_ep_responder u_dut (
    .clk(clk), .rst_n(rst_n), .ep_enable(ep_enable), .ep_iso(ep_iso),
    .stall_set(stall_set), .stall_clr(stall_clr), .stsack_set(stsack_set),
    .tok_valid(tok_valid), .tok_type(tok_type), .status_stage(status_stage),
    .tx_valid(tx_valid), .rx_free(rx_free), .host_ack(host_ack),
    .resp_valid(resp_valid), .resp_code(resp_code), .resp_data1(resp_data1),
    .stall_on(stall_on), .stsack_on(stsack_on), .toggle(toggle));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic idle;
    tok_valid = 0; stall_set = 0; stall_clr = 0; stsack_set = 0; host_ack = 0;
  endtask

  function automatic logic [3:0] model(input int tk, input bit st, input bit tx, input bit rx,
                                       input bit iso, input bit stl, input bit sa, input bit tg);
    if (tk == 2) return {1'b0, 3'd1};
    if (iso) return (tk == 1) ? (tx ? {1'b0, 3'd4} : {1'b0, 3'd5}) : 4'd0;
    if (stl) return {1'b0, 3'd3};
    if (st) begin
      if (!sa) return {1'b0, 3'd2};
      return (tk == 1) ? {1'b1, 3'd5} : {1'b0, 3'd1};
    end
    if (tk == 1) return tx ? {tg, 3'd4} : {1'b0, 3'd2};
    return rx ? {1'b0, 3'd1} : {1'b0, 3'd2};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] e;
    bit tog1, sa1, tog2, sa2;
    repeat (2) tick;
    // reset state
    chk("R11", "reset resp_valid", resp_valid, 0);
    chk("R10", "reset toggle", toggle, 0);
    chk("R12", "reset stall", stall_on, 0);
    chk("R4", "reset stsack", stsack_on, 0);
    rst_n = 1; ep_enable = 1; tick;

    // R1: SETUP and stsack_set in the same cycle, SETUP clear wins
    tok_valid = 1; tok_type = 2; stsack_set = 1; tick; idle;
    chk("R1", "setup+set stsack", stsack_on, 0);
    chk("R1", "setup resp", resp_code, 1);
    chk("R1", "setup toggle", toggle, 1);
    // R12: set and clear together
    stall_set = 1; stall_clr = 1; tick; idle;
    chk("R12", "set+clr stall", stall_on, 1);
    chk("R9", "toggle after stall", toggle, 1);
    stall_clr = 1; tick; idle;
    chk("R12", "stall cleared", stall_on, 0);
    chk("R9", "toggle after unstall", toggle, 1);
    // R11: token type 3 ignored
    tok_valid = 1; tok_type = 3; tick; idle;
    chk("R11", "type3 resp_valid", resp_valid, 0);
    // R10: disabled endpoint, then first packet DATA0
    ep_enable = 0; tok_valid = 1; tok_type = 1; tx_valid = 1; tick; idle;
    tick;
    chk("R10", "disabled resp_valid", resp_valid, 0);
    chk("R10", "disabled toggle", toggle, 0);
    ep_enable = 1; tok_valid = 1; tok_type = 1; status_stage = 0; tick; idle;
    chk("R10", "reenabled tag", resp_data1, 0);
    chk("R7", "reenabled data", resp_code, 4);
    // R8: token arriving with host_ack cancels the pending acknowledgement
    tok_valid = 1; tok_type = 1; tx_valid = 0; host_ack = 1; tick; idle;
    chk("R8", "ack with token", toggle, 0);
    chk("R7", "in nak", resp_code, 2);
    host_ack = 1; tick; idle;
    chk("R8", "ack without pending", toggle, 0);

    // sweep
    for (int tk = 0; tk < 3; tk++) begin
      for (int m = 0; m < 128; m++) begin
        bit st, tx, rx, iso, stl, sa, tg;
        {st, tx, rx, iso, stl, sa, tg} = 7'(m);
        idle; ep_iso = iso; ep_enable = 1;
        tok_valid = 1; tok_type = 2; stall_set = stl; stall_clr = !stl; tick; idle;
        chk("R1", "sweep setup ack", resp_code, 1);
        chk("R12", "sweep stall", stall_on, stl);
        stsack_set = sa; ep_enable = tg; tick; idle;
        chk("R10", "sweep toggle start", toggle, tg);
        chk("R4", "sweep stsack set", stsack_on, sa);
        ep_enable = 1; tok_valid = 1; tok_type = 2'(tk);
        status_stage = st; tx_valid = tx; rx_free = rx; tick; idle;
        e = model(tk, st, tx, rx, iso, stl, sa, tg);
        chk("R11", "sweep resp_valid", resp_valid, 1);
        chk(iso ? "R6" : stl ? "R5" : st ? (sa ? "R3" : "R2") : "R7", "sweep code", resp_code, e[2:0]);
        chk(iso ? "R6" : st ? "R3" : "R7", "sweep tag", resp_data1, e[3]);
        tog1 = tg;
        if (tk == 2) tog1 = 1;
        else if (!iso && !stl && !st && tk == 0 && rx) tog1 = !tg;
        sa1 = sa;
        if (tk == 2) sa1 = 0;
        else if (!iso && !stl && st && tk == 0 && sa) sa1 = 0;
        chk("R8", "sweep toggle", toggle, tog1);
        chk("R4", "sweep stsack", stsack_on, sa1);
        host_ack = 1; tick; idle;
        tog2 = (!iso && e[2:0] == 3'd4) ? !tog1 : tog1;
        sa2 = (!iso && e[2:0] == 3'd5) ? 1'b0 : sa1;
        chk("R11", "sweep quiet", resp_valid, 0);
        chk("R8", "sweep host_ack toggle", toggle, tog2);
        chk("R4", "sweep host_ack stsack", stsack_on, sa2);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule